// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every transmission the transmit engine reports as finished. It holds these bytes in a small store, and the host reads them through a status port. Each completion event carries four flags: an interrupt on success was requested, a jabber error, a transmit underrun, and the collision limit was reached. The host sees the oldest stored byte on the status port. Any write strobe on that port removes the byte the host is looking at.

When a completion arrives and every slot is taken, the new event is dropped. The newest stored byte is then marked with an overflow bit. An underrun or jabber completion stops the transmitter until the host issues a transmit reset. A transmit reset also empties the store. A summary event output stays high while any stored byte needs host attention.

The transmitter gate is a two-state machine. In RUN, `tx_enable` is high. The transition RUN to HALT is taken when a completion carries an underrun or jabber flag and no transmit reset is present. HALT holds on every other input. The transition HALT to RUN is taken on a transmit reset, and a transmit reset in RUN keeps the machine in RUN. Asynchronous reset puts the machine in RUN.

Top module: `tx_done_stack`

## Requirements
- R1: A stored byte reads as bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = collision limit, bit 2 = overflow, and bits 1:0 = 0.
- R2: `status_byte` shows the oldest stored byte. Bytes leave in the order they arrived. A store result is visible from the clock edge that follows the input.
- R3: The store holds DEPTH (4) bytes. A completion that arrives while the store is full, with no pop in the same cycle, is dropped. The same cycle sets bit 2 of the newest stored byte, and the count stays at DEPTH.
- R4: Every `host_status_wr` pulse removes the oldest byte. A pulse on an empty store has no effect. When a pop and a completion come in the same cycle, the pop acts first, so a full store accepts the new byte without overflow.
- R5: An empty store reads `status_byte` = 0x00, so bit 7 is clear.
- R6: A completion with underrun or jabber drives `tx_enable` low from the next edge. This holds whether the byte is stored or dropped. `tx_enable` stays low until a transmit reset. A collision-limit flag alone leaves `tx_enable` high.
- R7: A `tx_reset` pulse empties the store and raises `tx_enable` at the next edge. It takes precedence over a completion or pop in the same cycle.
- R8: `tx_done_event` is high exactly while at least one stored byte has bit 6 set or any of bits 5 to 2 set.
- R9: After `rst_n` the store is empty, `tx_enable` is high and `tx_done_event` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_reset | input | 1 | Transmit reset: empties the store and re-enables the transmitter |
| done_valid | input | 1 | A transmission completed this cycle |
| done_intr_req | input | 1 | An interrupt on success was requested for this frame |
| done_jabber | input | 1 | Jabber error on this frame |
| done_underrun | input | 1 | Underrun on this frame |
| done_max_coll | input | 1 | Collision limit reached on this frame |
| host_status_wr | input | 1 | Host write strobe to the status port (pop) |
| status_byte | output | 8 | Oldest stored status byte, or 0 when empty |
| tx_enable | output | 1 | Transmitter allowed to run |
| tx_done_event | output | 1 | At least one stored byte needs attention |

## Verification
The bench builds the block with DEPTH = 4. With that depth, the store fills after four completions, so overflow marking and a simultaneous pop and store on a full store are reached often under random traffic. These cases are also driven directly. A reference queue in the bench predicts the status byte, the gate and the event output for every cycle. Rare fault flags and occasional transmit resets make the machine visit both states many times.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int unsigned B_DONE = 7;
    localparam int unsigned B_INTR = 6;
    localparam int unsigned B_JAB  = 5;
    localparam int unsigned B_UND  = 4;
    localparam int unsigned B_MAXC = 3;
    localparam int unsigned B_OVF  = 2;
    localparam logic [7:0]  ATTN_MASK = 8'h7C;

    typedef enum logic {TXS_RUN = 1'b0, TXS_HALT = 1'b1} txen_state_t;

    function automatic logic [7:0] make_entry(input logic intr, input logic jab,
                                              input logic und, input logic maxc);
        logic [7:0] e;
        e = 8'h00;
        e[B_DONE] = 1'b1;
        e[B_INTR] = intr;
        e[B_JAB]  = jab;
        e[B_UND]  = und;
        e[B_MAXC] = maxc;
        return e;
    endfunction
endpackage

// File: rtl/txs_store.sv
module txs_store
    import txs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       pop,
    output logic [7:0] top_byte,
    output logic       event_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] attn;
    logic [PW-1:0] rd_ptr, wr_ptr, newest;
    logic [CW-1:0] cnt;
    logic          do_pop, room, do_store, mark_ovf;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop   = pop && (cnt != '0);
    assign room     = (cnt != FULL) || do_pop;
    assign do_store = push && room;
    assign mark_ovf = push && !room;
    assign newest   = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)   rd_ptr <= ptr_inc(rd_ptr);
            if (do_store) wr_ptr <= ptr_inc(wr_ptr);
            cnt <= cnt + CW'(do_store) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!clear) begin
            if (do_store) mem[wr_ptr] <= push_byte;
            if (mark_ovf) mem[newest][B_OVF] <= 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  vld[i] <= 1'b0;
            else if (clear)                              vld[i] <= 1'b0;
            else if (do_store && wr_ptr == PW'(i))       vld[i] <= 1'b1;
            else if (do_pop && rd_ptr == PW'(i))         vld[i] <= 1'b0;
        end
        assign attn[i] = vld[i] && ((mem[i] & ATTN_MASK) != 8'h00);
    end

    assign event_o  = |attn;
    assign top_byte = (cnt == '0) ? 8'h00 : mem[rd_ptr];

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && push && !pop && !clear) |=> (cnt == FULL && top_byte[B_DONE]));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && pop && !push && !clear) |=> (top_byte == 8'h00));
    p_top_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (top_byte[B_DONE] && top_byte[1:0] == 2'b00));
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (top_byte == 8'h00 && !event_o));
    p_event_needs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (cnt != '0));
endmodule

// File: rtl/txs_txen_fsm.sv
module txs_txen_fsm
    import txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_reset,
    input  logic fault_seen,
    output logic tx_enable
);
    txen_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TXS_RUN:  if (!tx_reset && fault_seen) state_nx = TXS_HALT;
            TXS_HALT: if (tx_reset)                state_nx = TXS_RUN;
            default:  state_nx = TXS_RUN;
        endcase
    end

    always_comb begin
        tx_enable = 1'b0;
        unique case (state)
            TXS_RUN:  tx_enable = 1'b1;
            TXS_HALT: tx_enable = 1'b0;
            default:  tx_enable = 1'b0;
        endcase
    end

    p_fault_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_seen && !tx_reset) |=> !tx_enable);
    p_halt_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !tx_reset) |=> !tx_enable);
    p_reset_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> tx_enable);
endmodule

// File: rtl/tx_done_stack.sv
module tx_done_stack
    import txs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_reset,
    input  logic       done_valid,
    input  logic       done_intr_req,
    input  logic       done_jabber,
    input  logic       done_underrun,
    input  logic       done_max_coll,
    input  logic       host_status_wr,
    output logic [7:0] status_byte,
    output logic       tx_enable,
    output logic       tx_done_event
);
    logic [7:0] entry;
    logic       fault_seen;

    assign entry      = make_entry(done_intr_req, done_jabber, done_underrun, done_max_coll);
    assign fault_seen = done_valid && (done_jabber || done_underrun);

    txs_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_reset),
        .push      (done_valid),
        .push_byte (entry),
        .pop       (host_status_wr),
        .top_byte  (status_byte),
        .event_o   (tx_done_event)
    );

    txs_txen_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_reset   (tx_reset),
        .fault_seen (fault_seen),
        .tx_enable  (tx_enable)
    );

    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_reset && !done_valid) |=> (status_byte == 8'h00));
endmodule

// File: tb/tx_done_stack_tb_top.sv
module tx_done_stack_tb_top;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_reset = 0, done_valid = 0, done_intr_req = 0, done_jabber = 0;
    logic done_underrun = 0, done_max_coll = 0, host_status_wr = 0;
    logic [7:0] status_byte;
    logic tx_enable, tx_done_event;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mq [DEPTH];
    int         mcnt = 0;
    logic       men = 1'b1;

    always #2 clk = ~clk;

    tx_done_stack #(.DEPTH(DEPTH)) dut_i (.*);

    function automatic logic [7:0] exp_top();
        return (mcnt == 0) ? 8'h00 : mq[0];
    endfunction

    function automatic logic exp_evt();
        logic e = 1'b0;
        for (int i = 0; i < mcnt; i++) if ((mq[i] & 8'h7C) != 0) e = 1'b1;
        return e;
    endfunction

    task automatic model_step();
        logic [7:0] e;
        if (tx_reset) begin
            mcnt = 0;
            men  = 1'b1;
            return;
        end
        if (host_status_wr && mcnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (done_valid) begin
            e = {1'b1, done_intr_req, done_jabber, done_underrun, done_max_coll, 3'b000};
            if (mcnt < DEPTH) begin
                mq[mcnt] = e;
                mcnt++;
            end else begin
                mq[DEPTH-1][2] = 1'b1;
            end
            if (done_jabber || done_underrun) men = 1'b0;
        end
    endtask

    task automatic check_all(input string tag);
        checks++;
        if (status_byte !== exp_top()) begin
            errors++;
            $display("FAIL %s status_byte act=%02h exp=%02h", tag, status_byte, exp_top());
        end
        checks++;
        if (tx_enable !== men) begin
            errors++;
            $display("FAIL %s tx_enable act=%0b exp=%0b", tag, tx_enable, men);
        end
        checks++;
        if (tx_done_event !== exp_evt()) begin
            errors++;
            $display("FAIL %s tx_done_event act=%0b exp=%0b", tag, tx_done_event, exp_evt());
        end
    endtask

    task automatic cyc(input logic v, input logic ir, input logic jb, input logic un,
                       input logic mc, input logic pp, input logic rs, input string tag);
        done_valid = v; done_intr_req = ir; done_jabber = jb; done_underrun = un;
        done_max_coll = mc; host_status_wr = pp; tx_reset = rs;
        model_step();
        @(negedge clk);
        done_valid = 0; host_status_wr = 0; tx_reset = 0;
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset state");
        cyc(1,1,0,0,0,0,0, "R1 intr entry 0xC0");
        cyc(0,0,0,0,0,1,0, "R5 empty after pop");
        cyc(0,0,0,0,0,1,0, "R4 pop on empty");
        cyc(1,0,0,0,1,0,0, "R6 max coll keeps enable");
        cyc(1,0,0,0,0,0,0, "R2 fill");
        cyc(1,1,0,0,0,0,0, "R2 fill");
        cyc(1,0,0,0,0,0,0, "R3 full");
        cyc(1,1,0,0,0,0,0, "R3 drop marks newest");
        for (int i = 0; i < 4; i++) cyc(0,0,0,0,0,1,0, "R3 drain order");
        for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,0,0, "R4 refill");
        cyc(1,1,0,0,0,1,0, "R4 pop and push when full");
        for (int i = 0; i < 4; i++) cyc(0,0,0,0,0,1,0, "R4 drain no overflow");
        cyc(1,0,0,1,0,0,0, "R6 underrun halts");
        cyc(0,0,0,0,0,1,0, "R6 pop keeps halt");
        cyc(0,0,0,0,0,0,1, "R7 reset re-enables");
        for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,0,0, "R3 fill");
        cyc(1,0,1,0,0,0,0, "R6 dropped jabber halts");
        cyc(1,0,1,0,0,1,1, "R7 reset wins");
        cyc(1,0,0,0,0,0,0, "R8 plain entry no event");
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            cyc(($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 12) == 0,
                ($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0,
                ($urandom % 40) == 0, "R2 random");
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule